// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-clock static RAM with a pipelined read path and four-beat bursts. Every synchronous pin is captured on the rising clock edge. The registered request then acts on the array at the following edge. A read word therefore reaches the output register on the second rising edge after the address was presented. Either of two address strobes starts a burst. After that, an advance input steps a 2-bit beat counter through the two low address bits, in interleaved or linear order.

Writes can update any subset of the byte lanes, or all lanes at once through a global write. Three chip selects must all be active for a strobe to start an access. Data in and data out are separate ports, with an output-enable that a tristate pad can use. The output-enable drops one cycle after any cycle that does not read, and an asynchronous output-enable input also gates it.

Top module: `sram_burst_pipe`

## Requirements
- R1: After reset, and with no strobe presented, `dout_oe` is 0.
- R2: A strobe starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe with any of these inactive ends the running burst, and no later cycle accesses the array until the next selected strobe.
- R3: Read data for a request presented before edge k is on `dout`, with `dout_oe`=1, after edge k+1.
- R4: With `lin_order`=0, the low two address bits of beat n are the start offset XOR n.
- R5: With `lin_order`=1, the low two address bits of beat n are (start offset + n) mod 4. The counter wraps after beat 3 and keeps stepping in the same order.
- R6: When `host_ld_n` is 0, the cycle is a read even if write enables are active, and `host_ld_n` wins over `ctl_ld_n`.
- R7: `step_n` has no effect in a strobe cycle, so the first beat uses the strobe address. In a burst cycle with `step_n`=1, the same address is accessed again.
- R8: `wr_all_n`=0 writes all lanes from `din`, whatever `lane_en_n` and `lane_wr_n` are.
- R9: With `wr_all_n`=1 and `lane_wr_n`=0, lane i (bits i*LW to i*LW+LW-1) is written only when `lane_en_n[i]`=0. With `wr_all_n`=1 and `lane_wr_n`=1, the cycle is a read.
- R10: After any cycle that writes or does not access the array, `dout_oe` is 0 (single-cycle deselect).
- R11: `dout_oe` is 0 whenever `out_en_n` is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| host_ld_n | input | 1 | Processor-side address strobe, forces read |
| ctl_ld_n | input | 1 | Controller-side address strobe |
| step_n | input | 1 | Burst advance |
| wr_all_n | input | 1 | Global write, all lanes |
| lane_wr_n | input | 1 | Gate for per-lane write enables |
| lane_en_n | input | NB | Per-lane write enables |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Asynchronous output-enable gate |
| dout | output | DW | Read data register |
| dout_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The hardest state to reach from the pins is a running burst whose counter has wrapped past beat 3 in linear order. The same holds for a burst that continues after a write, and for one that a deselected strobe has killed. In each case the array address depends on history that is not visible at the ports. Directed sequences produce a wrapped linear burst, stalled beats, a forced read under both strobes, and a deselecting strobe followed by advance cycles. Long random runs then mix strobes, advances, partial lane writes and order changes, so that bursts regularly cross these states. A bench model tracks the burst state and the array, and predicts each output two edges later.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
   localparam int BEAT_BITS = 2;

   // offset of a burst beat inside the four-word group
   function automatic logic [BEAT_BITS-1:0] beat_offset(
      input logic [BEAT_BITS-1:0] start,
      input logic [BEAT_BITS-1:0] beat,
      input logic                 linear);
      return linear ? (start + beat) : (start ^ beat);
   endfunction
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg #(
   parameter int AW = 8,
   parameter int DW = 36,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic          sel_a_n,
   input  logic          sel_b,
   input  logic          sel_c_n,
   input  logic          host_ld_n,
   input  logic          ctl_ld_n,
   input  logic          step_n,
   input  logic          wr_all_n,
   input  logic          lane_wr_n,
   input  logic [NB-1:0] lane_en_n,
   input  logic          lin_order,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_din,
   output logic          q_sel,
   output logic          q_host_ld_n,
   output logic          q_ctl_ld_n,
   output logic          q_step_n,
   output logic          q_wr_all_n,
   output logic          q_lane_wr_n,
   output logic [NB-1:0] q_lane_en_n,
   output logic          q_lin
);
   logic q_sel_a_n, q_sel_b, q_sel_c_n;

   // control pins: reset to an idle, deselected request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sel_a_n   <= 1'b1;
         q_sel_b     <= 1'b0;
         q_sel_c_n   <= 1'b1;
         q_host_ld_n <= 1'b1;
         q_ctl_ld_n  <= 1'b1;
         q_step_n    <= 1'b1;
         q_wr_all_n  <= 1'b1;
         q_lane_wr_n <= 1'b1;
         q_lane_en_n <= '1;
         q_lin       <= 1'b0;
      end else begin
         q_sel_a_n   <= sel_a_n;
         q_sel_b     <= sel_b;
         q_sel_c_n   <= sel_c_n;
         q_host_ld_n <= host_ld_n;
         q_ctl_ld_n  <= ctl_ld_n;
         q_step_n    <= step_n;
         q_wr_all_n  <= wr_all_n;
         q_lane_wr_n <= lane_wr_n;
         q_lane_en_n <= lane_en_n;
         q_lin       <= lin_order;
      end
   end

   // datapath pins carry no reset
   always_ff @(posedge clk) begin
      q_addr <= addr;
      q_din  <= din;
   end

   assign q_sel = ~q_sel_a_n & q_sel_b & ~q_sel_c_n;
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
   import sram_burst_pkg::*;
#(
   parameter int AW = 8,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] q_addr,
   input  logic          q_sel,
   input  logic          q_host_ld_n,
   input  logic          q_ctl_ld_n,
   input  logic          q_step_n,
   input  logic          q_wr_all_n,
   input  logic          q_lane_wr_n,
   input  logic [NB-1:0] q_lane_en_n,
   input  logic          q_lin,
   output logic          acc,
   output logic          wr,
   output logic [NB-1:0] lane_we,
   output logic [AW-1:0] eff_addr
);
   logic [AW-1:0]        base_q, base_n;
   logic [BEAT_BITS-1:0] cnt_q, cnt_n;
   logic                 act_q, act_n;
   logic                 strobe, wants_wr;

   assign strobe   = ~q_host_ld_n | ~q_ctl_ld_n;
   assign wants_wr = ~q_wr_all_n | ~q_lane_wr_n;

   always_comb begin
      base_n = base_q;
      cnt_n  = cnt_q;
      act_n  = act_q;
      acc    = 1'b0;
      wr     = 1'b0;
      if (strobe) begin
         act_n = q_sel;
         if (q_sel) begin
            base_n = q_addr;
            cnt_n  = '0;
            acc    = 1'b1;
            wr     = q_host_ld_n & wants_wr;
         end
      end else if (act_q) begin
         cnt_n = cnt_q + {{(BEAT_BITS-1){1'b0}}, ~q_step_n};
         acc   = 1'b1;
         wr    = wants_wr;
      end
   end

   assign eff_addr = {base_n[AW-1:BEAT_BITS], beat_offset(base_n[BEAT_BITS-1:0], cnt_n, q_lin)};
   assign lane_we  = !wr ? '0 : (!q_wr_all_n ? '1 : ~q_lane_en_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         base_q <= base_n;
         cnt_q  <= cnt_n;
         act_q  <= act_n;
      end
   end

   // R5: an advancing burst beat moves the counter by one, wrapping at four
   assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !strobe && !q_step_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

   // R7: a selected strobe restarts at beat zero regardless of the advance pin
   assert_strobe_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && q_sel) |=> (act_q && cnt_q == '0));

   // R2: a deselected strobe leaves no burst running
   assert_desel_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !q_sel) |=> !act_q);
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int DEPTH = 256,
   parameter int DW    = 36,
   parameter int NB    = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = DW / NB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic          wr,
   input  logic [NB-1:0] lane_we,
   input  logic [AW-1:0] eff_addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          oe_q
);
   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [LW-1:0] lane_mem [DEPTH];
      logic [LW-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (lane_we[g]) lane_mem[eff_addr] <= wdata[g*LW +: LW];
      end

      always_ff @(posedge clk) begin
         if (acc && !wr) rd_q <= lane_mem[eff_addr];
      end

      assign rdata[g*LW +: LW] = rd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= acc & ~wr;
   end

   // R10: no output drive after a cycle that wrote or left the array idle
   assert_single_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc || wr) |=> !oe_q);

   // R9: lane writes only occur within an accepted write cycle
   assert_lane_we_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we != '0) |-> (acc && wr));
endmodule

// File: rtl/sram_burst_pipe.sv
module sram_burst_pipe #(
   parameter int DEPTH = 256,
   parameter int DW    = 36,
   parameter int NB    = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic          sel_a_n,
   input  logic          sel_b,
   input  logic          sel_c_n,
   input  logic          host_ld_n,
   input  logic          ctl_ld_n,
   input  logic          step_n,
   input  logic          wr_all_n,
   input  logic          lane_wr_n,
   input  logic [NB-1:0] lane_en_n,
   input  logic          lin_order,
   input  logic          out_en_n,
   output logic [DW-1:0] dout,
   output logic          dout_oe
);
   if (DW % NB != 0) begin : g_bad_lanes
      $error("sram_burst_pipe: DW must split evenly into NB lanes");
   end
   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sram_burst_pipe: DEPTH must be a power of two of at least 4");
   end

   logic [AW-1:0] q_addr, eff_addr;
   logic [DW-1:0] q_din;
   logic          q_sel, q_host_ld_n, q_ctl_ld_n, q_step_n;
   logic          q_wr_all_n, q_lane_wr_n, q_lin;
   logic [NB-1:0] q_lane_en_n, lane_we;
   logic          acc, wr, oe_q;

   sram_in_reg #(.AW(AW), .DW(DW), .NB(NB)) u_in (
      .clk, .rst_n, .addr, .din, .sel_a_n, .sel_b, .sel_c_n,
      .host_ld_n, .ctl_ld_n, .step_n, .wr_all_n, .lane_wr_n, .lane_en_n,
      .lin_order,
      .q_addr, .q_din, .q_sel, .q_host_ld_n, .q_ctl_ld_n, .q_step_n,
      .q_wr_all_n, .q_lane_wr_n, .q_lane_en_n, .q_lin);

   sram_burst_ctl #(.AW(AW), .NB(NB)) u_ctl (
      .clk, .rst_n, .q_addr, .q_sel, .q_host_ld_n, .q_ctl_ld_n, .q_step_n,
      .q_wr_all_n, .q_lane_wr_n, .q_lane_en_n, .q_lin,
      .acc, .wr, .lane_we, .eff_addr);

   sram_lane_array #(.DEPTH(DEPTH), .DW(DW), .NB(NB)) u_arr (
      .clk, .rst_n, .acc, .wr, .lane_we, .eff_addr,
      .wdata(q_din), .rdata(dout), .oe_q);

   assign dout_oe = oe_q & ~out_en_n;

   // R6: a processor-side strobe on a selected device never writes
   assert_host_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_host_ld_n && q_sel) |-> (acc && !wr));

   // R9: neither write gate active means the access is a read
   assert_no_gate_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_wr_all_n && q_lane_wr_n) |-> !wr);

   // R11: bus drive never coexists with the asynchronous disable
   assert_async_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> !out_en_n);

   // R3: a read request shows up with drive enabled one edge after acceptance
   assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !wr) |=> oe_q);
endmodule

// File: tb/sram_burst_pipe_bench.sv
module sram_burst_pipe_bench;
   import sram_burst_pkg::*;
   localparam int DEPTH = 256;
   localparam int DW    = 36;
   localparam int NB    = 4;
   localparam int AW    = $clog2(DEPTH);
   localparam int LW    = DW / NB;

   typedef struct {
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
      logic sel_a_n, sel_b, sel_c_n, host_ld_n, ctl_ld_n, step_n;
      logic wr_all_n, lane_wr_n, lin, out_en_n;
      logic [NB-1:0] lane_en_n;
   } pins_t;

   typedef struct {
      logic          oe;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   logic sel_a_n, sel_b, sel_c_n, host_ld_n, ctl_ld_n, step_n;
   logic wr_all_n, lane_wr_n, lin_order, out_en_n, dout_oe;
   logic [NB-1:0] lane_en_n;

   always #4 clk = ~clk;

   sram_burst_pipe #(.DEPTH(DEPTH), .DW(DW), .NB(NB)) u_sram_burst_pipe (
      .clk, .rst_n, .addr, .din, .sel_a_n, .sel_b, .sel_c_n, .host_ld_n,
      .ctl_ld_n, .step_n, .wr_all_n, .lane_wr_n, .lane_en_n, .lin_order,
      .out_en_n, .dout, .dout_oe);

   int checks = 0, errors = 0;
   logic [DW-1:0] mdl [DEPTH];
   logic          b_act = 1'b0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   exp_t pend0, pend1;
   pins_t cur;
   logic cur_lin = 1'b0;

   function automatic pins_t p_idle();
      pins_t p;
      p.addr = '0; p.din = '0;
      p.sel_a_n = 1'b1; p.sel_b = 1'b0; p.sel_c_n = 1'b1;
      p.host_ld_n = 1'b1; p.ctl_ld_n = 1'b1; p.step_n = 1'b1;
      p.wr_all_n = 1'b1; p.lane_wr_n = 1'b1; p.lane_en_n = '1;
      p.lin = cur_lin; p.out_en_n = 1'b0;
      return p;
   endfunction

   function automatic pins_t p_sel(input pins_t p);
      p.sel_a_n = 1'b0; p.sel_b = 1'b1; p.sel_c_n = 1'b0;
      return p;
   endfunction

   function automatic pins_t p_rd(input logic [AW-1:0] a);
      pins_t p = p_sel(p_idle());
      p.addr = a; p.ctl_ld_n = 1'b0;
      return p;
   endfunction

   function automatic pins_t p_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      pins_t p = p_rd(a);
      p.din = d; p.wr_all_n = 1'b0;
      return p;
   endfunction

   function automatic pins_t p_adv();
      pins_t p = p_idle();
      p.step_n = 1'b0;
      return p;
   endfunction

   // bench model of one request, evaluated in request order
   function automatic exp_t model(input pins_t p, input string tag);
      exp_t e;
      logic sel, strobe, wreq, acc, wr;
      logic [AW-1:0] a;
      e.oe = 1'b0; e.data = '0; e.tag = tag;
      sel    = !p.sel_a_n && p.sel_b && !p.sel_c_n;
      strobe = !p.host_ld_n || !p.ctl_ld_n;
      wreq   = !p.wr_all_n || !p.lane_wr_n;
      acc = 1'b0; wr = 1'b0; a = '0;
      if (strobe) begin
         b_act = sel;
         if (sel) begin
            b_base = p.addr; b_cnt = 2'd0; acc = 1'b1;
            wr = p.host_ld_n && wreq;
         end
      end else if (b_act) begin
         if (!p.step_n) b_cnt = b_cnt + 2'd1;
         acc = 1'b1; wr = wreq;
      end
      a = {b_base[AW-1:2], p.lin ? b_base[1:0] + b_cnt : b_base[1:0] ^ b_cnt};
      if (acc && wr) begin
         for (int i = 0; i < NB; i++)
            if (!p.wr_all_n || !p.lane_en_n[i]) mdl[a][i*LW +: LW] = p.din[i*LW +: LW];
      end else if (acc) begin
         e.oe = 1'b1; e.data = mdl[a];
      end
      return e;
   endfunction

   task automatic drive(input pins_t p);
      addr = p.addr; din = p.din; sel_a_n = p.sel_a_n; sel_b = p.sel_b;
      sel_c_n = p.sel_c_n; host_ld_n = p.host_ld_n; ctl_ld_n = p.ctl_ld_n;
      step_n = p.step_n; wr_all_n = p.wr_all_n; lane_wr_n = p.lane_wr_n;
      lane_en_n = p.lane_en_n; lin_order = p.lin; out_en_n = p.out_en_n;
      cur = p;
   endtask

   // one clock: check the request issued two cycles ago, then issue a new one
   task automatic cyc(input pins_t p, input string tag);
      logic eoe;
      @(negedge clk);
      eoe = pend1.oe && !cur.out_en_n;
      checks++;
      if (dout_oe !== eoe) begin
         errors++;
         $display("FAIL %s: dout_oe actual=%0b expected=%0b", pend1.tag, dout_oe, eoe);
      end
      if (eoe) begin
         checks++;
         if (dout !== pend1.data) begin
            errors++;
            $display("FAIL %s: dout actual=%h expected=%h", pend1.tag, dout, pend1.data);
         end
      end
      pend1 = pend0;
      pend0 = model(p, tag);
      drive(p);
   endtask

   task automatic flush(input string tag);
      for (int i = 0; i < 3; i++) cyc(p_idle(), tag);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      pins_t p;
      void'($urandom(32'd4242));
      pend0.oe = 1'b0; pend0.data = '0; pend0.tag = "R1";
      pend1 = pend0;
      drive(p_idle());
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (dout_oe !== 1'b0) begin
         errors++;
         $display("FAIL R1: dout_oe in reset actual=%0b expected=0", dout_oe);
      end
      rst_n = 1'b1;
      flush("R1");

      // fill with global writes; lane enables set to prove they are ignored (R8)
      for (int a = 0; a < DEPTH; a++) begin
         p = p_wr(a[AW-1:0], {$urandom(), $urandom()});
         p.lane_en_n = '1; p.lane_wr_n = 1'b1;
         cyc(p, "R8");
      end
      flush("R10");

      // interleaved burst from offset 2, then wrap with linear from offset 3
      cur_lin = 1'b0;
      cyc(p_rd(8'h12), "R4");
      for (int i = 0; i < 3; i++) cyc(p_adv(), "R4");
      cur_lin = 1'b1;
      cyc(p_rd(8'h27), "R5");
      for (int i = 0; i < 6; i++) cyc(p_adv(), "R5");
      flush("R10");

      // advance during strobe ignored; stalled beat repeats address
      p = p_rd(8'h31); p.step_n = 1'b0;
      cyc(p, "R7");
      cyc(p_idle(), "R7");
      cyc(p_adv(), "R7");
      cyc(p_idle(), "R7");
      flush("R10");

      // both strobes low with global write: read, array untouched
      p = p_wr(8'h40, '1); p.host_ld_n = 1'b0;
      cyc(p, "R6");
      cyc(p_rd(8'h40), "R6");
      flush("R6");

      // lane writes: lanes 0 and 2, then a gate-off cycle that must read
      p = p_rd(8'h50); p.din = {$urandom(), $urandom()};
      p.lane_wr_n = 1'b0; p.lane_en_n = 4'b1010;
      cyc(p, "R9");
      p = p_rd(8'h50); p.lane_en_n = 4'b0000;
      cyc(p, "R9");
      flush("R9");

      // each select inactive in turn, then advances after a dead strobe
      p = p_rd(8'h60); p.sel_a_n = 1'b1; cyc(p, "R2");
      p = p_rd(8'h60); p.sel_b   = 1'b0; cyc(p, "R2");
      p = p_rd(8'h60); p.sel_c_n = 1'b1; cyc(p, "R2");
      cyc(p_adv(), "R2");
      cyc(p_adv(), "R2");
      flush("R2");

      // read then deselect; read with asynchronous disable held
      cyc(p_rd(8'h70), "R10");
      cyc(p_idle(), "R10");
      flush("R10");
      p = p_rd(8'h71); p.out_en_n = 1'b1;
      cyc(p, "R11");
      p = p_adv(); p.out_en_n = 1'b1;
      cyc(p, "R11");
      p = p_idle(); p.out_en_n = 1'b1;
      cyc(p, "R11");
      cyc(p, "R11");
      flush("R11");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         p = p_idle();
         p.addr = AW'($urandom());
         p.din = {$urandom(), $urandom()};
         p.sel_a_n = ($urandom() % 16 == 0);
         p.sel_b   = ($urandom() % 16 != 0);
         p.sel_c_n = ($urandom() % 16 == 0);
         p.host_ld_n = ($urandom() % 6 != 0);
         p.ctl_ld_n  = ($urandom() % 5 != 0);
         p.step_n    = ($urandom() % 2 != 0);
         p.wr_all_n  = ($urandom() % 4 != 0);
         p.lane_wr_n = ($urandom() % 3 != 0);
         p.lane_en_n = NB'($urandom());
         if ($urandom() % 50 == 0) cur_lin = ~cur_lin;
         p.lin = cur_lin;
         p.out_en_n = ($urandom() % 10 == 0);
         cyc(p, "R3");
      end
      flush("R3");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule